// File: doc/BRIEF.md
# Serial byte-command controller

This block sits at the device end of a slow host link. The host clocks one-byte commands in over a two-wire input: a data wire and a strobe wire. The block decodes each command and replies over a two-wire output of the same shape: a data wire and a strobe wire. The command rate is far below the core clock, so test computation runs on-chip. The host only asks for status, starts a run, and collects a 32-bit summary word when the run is over.

The block has four command responses. A status query answers ready (0xAB) or busy (0xAC). A start command pulses `test_start` to an external test engine and marks a run as in progress. A fetch command returns a data header (0xDA) followed by the result word. Any other byte is answered with 0xAE ("not understood"). The test engine ends a run with a one-cycle `test_done` pulse. On that pulse the block latches `test_result`.

Control is a four-state machine:
- **IDLE** waits for a received byte, taking the *accept* transition to **DECODE**.
- **DECODE** picks the reply byte, possibly starts a run or arms the result bytes, and moves on by the *issue* transition to **LOAD**.
- **LOAD** hands one byte to the serializer, and the *launch* transition goes to **WAIT**.
- **WAIT** holds until the serializer is free. It then takes the *next* transition back to **LOAD** while result bytes remain, or the *finish* transition to **IDLE**.

Bytes that arrive outside IDLE are dropped, so the host waits for the complete reply before it sends again.

Top module: `byte_cmd_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and in the first cycle after it, `tx_ctrl`, `tx_data` and `test_start` are low. The run-in-progress flag is clear, so a status query after reset answers 0xAB.
- R2: An incoming byte is assembled MSB first. Each bit is the value of `rx_data` taken at a rising edge of `rx_ctrl`, and the eighth rising edge completes the byte.
- R3: Each reply byte is sent MSB first as eight rising edges of `tx_ctrl`, spaced 2*TX_HALF clock cycles apart. Within a byte, `tx_ctrl` is high for TX_HALF cycles and low for TX_HALF cycles per bit, and `tx_data` does not change while `tx_ctrl` is high.
- R4: Status query 0xAA answers 0xAC while a run is in progress and 0xAB otherwise.
- R5: Start command 0xBA with no run in progress answers 0xAB. It drives `test_start` high for exactly one cycle and marks a run as in progress.
- R6: Start command 0xBA during a run answers 0xAC and produces no `test_start` pulse.
- R7: Fetch command 0xBD during a run answers 0xAC only.
- R8: Fetch command 0xBD with no run in progress answers 0xDA and then the four bytes of the latched result, most significant byte first. Before any run has completed, the latched result is zero.
- R9: Any byte other than 0xAA, 0xBA or 0xBD answers 0xAE. It causes no `test_start` pulse and leaves the run flag and the latched result unchanged.
- R10: A `test_done` pulse during a run clears the run flag and latches `test_result` as the value later returned by the fetch command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Command data wire from the host |
| rx_ctrl | input | 1 | Command strobe wire; rising edge samples `rx_data` |
| tx_data | output | 1 | Reply data wire to the host |
| tx_ctrl | output | 1 | Reply strobe wire; rising edge marks a valid `tx_data` bit |
| test_start | output | 1 | One-cycle pulse that launches the test engine |
| test_done | input | 1 | One-cycle pulse from the test engine at the end of a run |
| test_result | input | 32 | Summary word from the test engine, latched on `test_done` |

## Verification
Some properties are checked by the assertions on every cycle:
- the quiet outputs after reset;
- data stability while the reply strobe is high;
- the single-cycle shape of the start pulse, and that it never comes while a run is in progress;
- the run flag clearing on `test_done`.

Other behaviour shows only in the bench's host-level scenarios. These cover the command vocabulary and the reply codes chosen in each run state, the order and content of the five-byte result reply, and the spacing of the strobe edges. They also show that unknown bytes leave the status answers and the returned result as they were.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int BYTE_W = 8;

    // Command vocabulary (host to device)
    localparam logic [BYTE_W-1:0] CMD_QUERY = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_START = 8'hBA;
    localparam logic [BYTE_W-1:0] CMD_FETCH = 8'hBD;

    // Reply vocabulary (device to host)
    localparam logic [BYTE_W-1:0] RSP_READY  = 8'hAB;
    localparam logic [BYTE_W-1:0] RSP_BUSY   = 8'hAC;
    localparam logic [BYTE_W-1:0] RSP_UNKNOW = 8'hAE;
    localparam logic [BYTE_W-1:0] RSP_HEADER = 8'hDA;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_LOAD   = 2'd2,
        ST_WAIT   = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/bcc_rx_deser.sv
module bcc_rx_deser #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_data,
    input  logic       rx_ctrl,
    output logic       byte_valid,
    output logic [7:0] byte_out
);
    localparam int BW = bcc_pkg::BYTE_W;
    localparam int CNT_W = $clog2(BW);

    logic [SYNC_DEPTH-1:0] dsync_q;
    logic [SYNC_DEPTH-1:0] csync_q;
    logic                  cprev_q;
    logic                  strobe_rise;
    logic [CNT_W-1:0]      bitcnt_q;
    logic [BW-1:0]         shift_q;
    logic                  valid_q;

    // Bring both wires into the clock domain through equal-length chains
    generate
        if (SYNC_DEPTH == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) begin
                    dsync_q <= '0;
                    csync_q <= '0;
                end else begin
                    dsync_q <= rx_data;
                    csync_q <= rx_ctrl;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) begin
                    dsync_q <= '0;
                    csync_q <= '0;
                end else begin
                    dsync_q <= {dsync_q[SYNC_DEPTH-2:0], rx_data};
                    csync_q <= {csync_q[SYNC_DEPTH-2:0], rx_ctrl};
                end
            end
        end
    endgenerate

    assign strobe_rise = csync_q[SYNC_DEPTH-1] & ~cprev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cprev_q  <= 1'b0;
            bitcnt_q <= '0;
            shift_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            cprev_q <= csync_q[SYNC_DEPTH-1];
            valid_q <= 1'b0;
            if (strobe_rise) begin
                shift_q  <= {shift_q[BW-2:0], dsync_q[SYNC_DEPTH-1]};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == CNT_W'(BW - 1)) begin
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign byte_valid = valid_q;
    assign byte_out   = shift_q;

endmodule

// File: rtl/bcc_tx_ser.sv
module bcc_tx_ser #(
    parameter int TX_HALF = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] byte_in,
    output logic       busy,
    output logic       tx_data,
    output logic       tx_ctrl
);
    localparam int BW = bcc_pkg::BYTE_W;
    localparam int CNT_W = $clog2(BW);
    localparam int TW = (TX_HALF > 1) ? $clog2(TX_HALF) : 1;
    localparam logic [TW-1:0]    T_LAST = TW'(TX_HALF - 1);
    localparam logic [CNT_W-1:0] B_LAST = CNT_W'(BW - 1);

    logic [BW-1:0]    sr_q;
    logic [CNT_W-1:0] bit_q;
    logic [TW-1:0]    tmr_q;
    logic             hi_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            bit_q  <= '0;
            tmr_q  <= '0;
            hi_q   <= 1'b0;
            busy_q <= 1'b0;
        end else if (load && !busy_q) begin
            sr_q   <= byte_in;
            bit_q  <= '0;
            tmr_q  <= '0;
            hi_q   <= 1'b0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (tmr_q == T_LAST) begin
                tmr_q <= '0;
                if (!hi_q) begin
                    hi_q <= 1'b1;
                end else begin
                    hi_q <= 1'b0;
                    if (bit_q == B_LAST) begin
                        busy_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sr_q  <= {sr_q[BW-2:0], 1'b0};
                    end
                end
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign tx_data = busy_q & sr_q[BW-1];
    assign tx_ctrl = hi_q;

endmodule

// File: rtl/bcc_ctrl_fsm.sv
module bcc_ctrl_fsm
    import bcc_pkg::*;
#(
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             tx_busy,
    output logic             tx_load,
    output logic [7:0]       tx_byte,
    input  logic             test_done,
    input  logic [RES_W-1:0] test_result,
    output logic             test_start,
    output logic             run_flag
);
    localparam int NB = RES_W / BYTE_W;
    localparam int CW = $clog2(NB + 1);

    ctl_state_e       state_q, state_d;
    logic [7:0]       cmd_q;
    logic [7:0]       resp_q, resp_d;
    logic [CW-1:0]    left_q;
    logic [RES_W-1:0] shr_q;
    logic [RES_W-1:0] res_q;
    logic             run_q;
    logic             start_q;
    logic             start_go;
    logic             data_go;
    logic             more_bytes;

    assign more_bytes = (left_q != '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, reply selection and strobes
    always_comb begin
        state_d  = state_q;
        resp_d   = RSP_UNKNOW;
        start_go = 1'b0;
        data_go  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                case (cmd_q)
                    CMD_QUERY: resp_d = run_q ? RSP_BUSY : RSP_READY;
                    CMD_START: begin
                        resp_d   = run_q ? RSP_BUSY : RSP_READY;
                        start_go = !run_q;
                    end
                    CMD_FETCH: begin
                        resp_d  = run_q ? RSP_BUSY : RSP_HEADER;
                        data_go = !run_q;
                    end
                    default: resp_d = RSP_UNKNOW;
                endcase
                state_d = ST_LOAD;
            end
            ST_LOAD: state_d = ST_WAIT;
            ST_WAIT: begin
                if (!tx_busy) state_d = more_bytes ? ST_LOAD : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        tx_load    = (state_q == ST_LOAD);
        tx_byte    = resp_q;
        test_start = start_q;
        run_flag   = run_q;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            resp_q  <= '0;
            left_q  <= '0;
            shr_q   <= '0;
            res_q   <= '0;
            run_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_go;
            if (state_q == ST_IDLE && rx_valid) begin
                cmd_q <= rx_byte;
            end
            if (state_q == ST_DECODE) begin
                resp_q <= resp_d;
                if (data_go) begin
                    left_q <= CW'(NB);
                    shr_q  <= res_q;
                end
            end
            if (state_q == ST_WAIT && !tx_busy && more_bytes) begin
                resp_q <= shr_q[RES_W-1 -: BYTE_W];
                shr_q  <= {shr_q[RES_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                left_q <= left_q - 1'b1;
            end
            if (start_go) begin
                run_q <= 1'b1;
            end else if (test_done && run_q) begin
                run_q <= 1'b0;
                res_q <= test_result;
            end
        end
    end

endmodule

// File: rtl/byte_cmd_ctrl.sv
module byte_cmd_ctrl #(
    parameter int TX_HALF    = 16,
    parameter int SYNC_DEPTH = 2,
    parameter int RES_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_data,
    input  logic             rx_ctrl,
    output logic             tx_data,
    output logic             tx_ctrl,
    output logic             test_start,
    input  logic             test_done,
    input  logic [RES_W-1:0] test_result
);
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       tx_busy;
    logic       tx_load;
    logic [7:0] tx_byte;
    logic       run_flag;

    bcc_rx_deser #(.SYNC_DEPTH(SYNC_DEPTH)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data),
        .rx_ctrl    (rx_ctrl),
        .byte_valid (rx_valid),
        .byte_out   (rx_byte)
    );

    bcc_ctrl_fsm #(.RES_W(RES_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_busy     (tx_busy),
        .tx_load     (tx_load),
        .tx_byte     (tx_byte),
        .test_done   (test_done),
        .test_result (test_result),
        .test_start  (test_start),
        .run_flag    (run_flag)
    );

    bcc_tx_ser #(.TX_HALF(TX_HALF)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .byte_in (tx_byte),
        .busy    (tx_busy),
        .tx_data (tx_data),
        .tx_ctrl (tx_ctrl)
    );

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic clk,
    input logic rst,
    input logic tx_data,
    input logic tx_ctrl,
    input logic test_start,
    input logic test_done,
    input logic run_flag
);
    // R1: quiet outputs in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_ctrl && !tx_data && !test_start));

    // R3: data wire holds while the reply strobe stays high
    a_r3_data_steady_high: assert property (@(posedge clk) disable iff (rst)
        (tx_ctrl && $past(tx_ctrl)) |-> $stable(tx_data));

    // R5: start pulse lasts one cycle
    a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
        test_start |=> !test_start);

    // R5: start pulse comes with the run flag set
    a_r5_start_marks_run: assert property (@(posedge clk) disable iff (rst)
        test_start |-> run_flag);

    // R6: no start pulse when a run was already in progress
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        test_start |-> !$past(run_flag));

    // R10: completion clears the run flag
    a_r10_done_clears: assert property (@(posedge clk) disable iff (rst)
        (test_done && run_flag) |=> !run_flag);

endmodule

bind byte_cmd_ctrl bcc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_data    (tx_data),
    .tx_ctrl    (tx_ctrl),
    .test_start (test_start),
    .test_done  (test_done),
    .run_flag   (run_flag)
);

// File: tb/tb_byte_cmd_ctrl.sv
module tb_byte_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TX_HALF    = 4;
    localparam int HOST_HALF  = 6;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_data = 1'b0;
    logic        rx_ctrl = 1'b0;
    logic        tx_data;
    logic        tx_ctrl;
    logic        test_start;
    logic        test_done = 1'b0;
    logic [31:0] test_result = '0;

    int errors = 0;
    int checks = 0;
    int starts_seen = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_cmd_ctrl #(.TX_HALF(TX_HALF)) dut (
        .clk         (clk),
        .rst         (rst),
        .rx_data     (rx_data),
        .rx_ctrl     (rx_ctrl),
        .tx_data     (tx_data),
        .tx_ctrl     (tx_ctrl),
        .test_start  (test_start),
        .test_done   (test_done),
        .test_result (test_result)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    // Host side: MSB first, data set up before each strobe rise (R2)
    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            rx_data = b[i];
            repeat (HOST_HALF) @(negedge clk);
            rx_ctrl = 1'b1;
            repeat (HOST_HALF) @(negedge clk);
            rx_ctrl = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4 * TX_HALF) @(negedge clk);
    endtask

    task automatic command(input logic [7:0] cmd, input logic [7:0] rsp, input string req);
        expect_byte(rsp, req);
        send_byte(cmd);
        drain();
    endtask

    task automatic fetch_ok(input logic [31:0] word, input string req);
        expect_byte(8'hDA, req);
        for (int k = 3; k >= 0; k--) expect_byte(word[k*8 +: 8], req);
        send_byte(8'hBD);
        drain();
    endtask

    task automatic finish_run(input logic [31:0] word);
        test_result = word;
        test_done   = 1'b1;
        @(negedge clk);
        test_done   = 1'b0;
        test_result = 32'h0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: rebuilds reply bytes and compares against the scoreboard
    logic [7:0] mon_byte = '0;
    int         mon_bits = 0;
    int         mon_since = 0;
    bit         mon_bad = 1'b0;
    logic       prev_ctrl = 1'b0;
    logic       prev_data = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_ctrl && prev_ctrl && (tx_data != prev_data)) mon_bad = 1'b1;
            if (tx_ctrl && !prev_ctrl) begin
                if (mon_bits != 0 && mon_since != 2 * TX_HALF) mon_bad = 1'b1;
                mon_byte  = {mon_byte[6:0], tx_data};
                mon_bits  = mon_bits + 1;
                mon_since = 1;
                if (mon_bits == 8) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected byte", {24'h0, mon_byte}, 32'h0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(mon_byte == e, t, {24'h0, mon_byte}, {24'h0, e});
                    end
                    check(!mon_bad, "R3 strobe framing", {31'h0, mon_bad}, 32'h0);
                    mon_bad  = 1'b0;
                    mon_bits = 0;
                end
            end else begin
                mon_since = mon_since + 1;
            end
            if (test_start) starts_seen = starts_seen + 1;
        end
        prev_ctrl = tx_ctrl;
        prev_data = tx_data;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs quiet while reset is held
        check(!tx_ctrl && !tx_data && !test_start, "R1 reset outputs",
              {29'h0, tx_ctrl, tx_data, test_start}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_ctrl && !tx_data && !test_start, "R1 after reset",
              {29'h0, tx_ctrl, tx_data, test_start}, 32'h0);

        command(8'hAA, 8'hAB, "R1 R2 R4 status idle");
        fetch_ok(32'h0, "R8 fetch before any run");

        command(8'h55, 8'hAE, "R9 unknown byte");
        command(8'hAB, 8'hAE, "R9 reply code as command");
        command(8'hAA, 8'hAB, "R9 status unchanged");
        check(starts_seen == 0, "R9 no start pulse", starts_seen, 0);

        command(8'hBA, 8'hAB, "R5 start from idle");
        check(starts_seen == 1, "R5 one start pulse", starts_seen, 1);
        command(8'hAA, 8'hAC, "R4 status running");
        command(8'hBA, 8'hAC, "R6 start while running");
        check(starts_seen == 1, "R6 no restart pulse", starts_seen, 1);
        command(8'hBD, 8'hAC, "R7 fetch while running");
        command(8'h00, 8'hAE, "R9 unknown while running");
        command(8'hAA, 8'hAC, "R9 run flag kept");

        finish_run(32'hDEADBEEF);
        command(8'hAA, 8'hAB, "R10 run flag cleared");
        fetch_ok(32'hDEADBEEF, "R8 R10 result bytes");
        command(8'hFF, 8'hAE, "R9 unknown after run");
        fetch_ok(32'hDEADBEEF, "R9 result unchanged");

        command(8'hBA, 8'hAB, "R5 second start");
        check(starts_seen == 2, "R5 second pulse", starts_seen, 2);
        finish_run(32'h0123A5F0);
        fetch_ok(32'h0123A5F0, "R8 R10 second result");

        // test_done with no run in progress must not replace the result
        finish_run(32'h77777777);
        fetch_ok(32'h0123A5F0, "R10 idle done ignored");
        check(exp_q.size() == 0, "R3 all replies received", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule